// File: doc/BRIEF.md
# Three-Mode Instruction Predecoder with Mode-Switch Redirect

This block sits directly behind instruction fetch in a core that runs three instruction-set modes: plain RV64GC, a co-execute mode that mixes native and RISC-V words, and a native mode with 64 unified registers. It keeps the current mode in a register. For every fetched 32-bit word it reports the instruction length, the instruction class and an illegal flag. These results are combinational and depend on the current mode and on the two lowest bits of the word.

The block also recognises loads whose destination is register zero, which act as mode-changing branches. It presents the index of the load's base register to the register file and receives that register's value back in the same cycle. It adds the signed displacement to form a target. On the next clock edge it either raises a one-cycle redirect carrying the new mode and target, or raises a one-cycle fault if the target is misaligned. Words that follow jumbo prefixes are marked as tails of a wider instruction.

Top module: `isa_predecode`

## Requirements
- R1: After reset the mode is RV64GC (cur_mode 0; co-execute is 1, native is 2), and redir_valid and switch_fault are 0.
- R2: In RV64GC mode, low bits 00, 01 and 10 give iclass 0 (compressed) with ilen_h 1 (halfwords), and low bits 11 give iclass 1 (RISC-V 32-bit) with ilen_h 2. None of these is illegal.
- R3: In co-execute or native mode every word has ilen_h 2. Low bits 00 give iclass 2 (native), 01 give iclass 3 (jumbo prefix), 10 give iclass 4 (reserved) with illegal set, and 11 give iclass 1.
- R4: A native word (low bits 00 outside RV64GC mode) whose bits [3:2] are 01 is flagged illegal. Bits [3:2] of 00, 10 and 11 are legal.
- R5: A RISC-V load is a mode switch when it has opcode bits [6:0] = 0000011 and destination [11:7] = 0. Funct3 [14:12] = 100 selects RV64GC, 110 selects co-execute and 101 selects native. The target is base_val plus the sign-extended bits [31:20]. The redirect is recognised in every mode.
- R6: A native switch is recognised only outside RV64GC mode. It needs low bits 00, bits [3:2] = 11, bits [15:8] = 0, and bits [7:4] = 0100 (to RV64GC), 0110 (to co-execute) or 0101 (to native). The target is base_val plus the sign-extended bits [31:22]. In RV64GC mode the same word is a compressed instruction and does not switch.
- R7: base_idx is bits [21:16] for a native word and {0, bits [19:15]} otherwise.
- R8: An accepted switch raises redir_valid for exactly one cycle, starting at the next clock edge. At that edge cur_mode becomes the new mode, and redir_mode and redir_pc show the new mode and the target. A load with a nonzero destination or another funct3 does not switch.
- R9: A target entering RV64GC mode must have bit 0 clear. A target entering either other mode must have bits [1:0] clear. If the target is misaligned, switch_fault pulses for one cycle instead, with no redirect and no change of mode.
- R10: A word presented while redir_valid or switch_fault is high is dropped. It causes no switch.
- R11: A word that follows one or two consecutive jumbo prefixes has jumbo_tail set. A third consecutive prefix is illegal and ends the chain. A switch load that carries jumbo_tail does not switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A fetched word is present |
| in_word | input | 32 | Fetched instruction word |
| base_val | input | XLEN | Value of the register named by base_idx |
| base_idx | output | 6 | Base register index of the presented word |
| cur_mode | output | 2 | Current mode: 0 RV64GC, 1 co-execute, 2 native |
| ilen_h | output | 2 | Instruction length in halfwords |
| iclass | output | 3 | Class: 0 compressed, 1 RISC-V, 2 native, 3 jumbo, 4 reserved |
| illegal | output | 1 | Presented valid word is illegal |
| jumbo_tail | output | 1 | Presented word continues a jumbo prefix chain |
| redir_valid | output | 1 | One-cycle redirect to a new mode |
| redir_mode | output | 2 | Mode carried by the redirect |
| redir_pc | output | XLEN | Redirect target address |
| switch_fault | output | 1 | One-cycle misaligned-target fault |

## Verification
The length, class, illegal, base index and jumbo-tail results are combinational, so they are due in the same cycle as the word. The bench samples them 5 ns after the negative edge on which it drove the word. The redirect, the fault, the new mode and the redirect target are due one clock edge after the word. They are sampled at the following negative edge, and one further negative edge shows the redirect low again. A word driven in the cycle after a switch is sampled while the redirect is still high, which checks the drop rule exactly where it applies.

// File: rtl/isa_predecode.sv
module isa_predecode #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_word,
  input  logic [XLEN-1:0] base_val,
  output logic [5:0]      base_idx,
  output logic [1:0]      cur_mode,
  output logic [1:0]      ilen_h,
  output logic [2:0]      iclass,
  output logic            illegal,
  output logic            jumbo_tail,
  output logic            redir_valid,
  output logic [1:0]      redir_mode,
  output logic [XLEN-1:0] redir_pc,
  output logic            switch_fault
);
  localparam logic [1:0] M_RV = 2'd0, M_CX = 2'd1, M_NT = 2'd2;
  localparam logic [2:0] C_RVC = 3'd0, C_RV32 = 3'd1, C_NAT = 3'd2, C_JMB = 3'd3, C_RSV = 3'd4;
  localparam logic [1:0] JMAX = 2'd2;

  logic [1:0]      jcnt;
  logic            hit;
  logic [1:0]      tmode;
  logic [XLEN-1:0] disp;

  wire       rv_mode  = (cur_mode == M_RV);
  wire [1:0] lo       = in_word[1:0];
  wire       nat_word = !rv_mode && (lo == 2'b00);

  always_comb begin
    ilen_h  = 2'd2;
    iclass  = C_RV32;
    illegal = 1'b0;
    if (rv_mode) begin
      if (lo != 2'b11) begin
        ilen_h = 2'd1;
        iclass = C_RVC;
      end
    end else begin
      case (lo)
        2'b00: begin
          iclass  = C_NAT;
          illegal = in_valid && (in_word[3:2] == 2'b01);
        end
        2'b01: begin
          iclass  = C_JMB;
          illegal = in_valid && (jcnt == JMAX);
        end
        2'b10: begin
          iclass  = C_RSV;
          illegal = in_valid;
        end
        default: ;
      endcase
    end
  end

  assign jumbo_tail = in_valid && (jcnt != 2'd0);
  assign base_idx   = nat_word ? in_word[21:16] : {1'b0, in_word[19:15]};

  always_comb begin
    hit   = 1'b0;
    tmode = M_RV;
    disp  = {{(XLEN-12){in_word[31]}}, in_word[31:20]};
    if (lo == 2'b11 && in_word[6:2] == 5'b00000 && in_word[11:7] == 5'd0) begin
      hit = 1'b1;
      case (in_word[14:12])
        3'b100:  tmode = M_RV;
        3'b110:  tmode = M_CX;
        3'b101:  tmode = M_NT;
        default: hit = 1'b0;
      endcase
    end else if (nat_word && in_word[3:2] == 2'b11 && in_word[15:8] == 8'h00) begin
      hit  = 1'b1;
      disp = {{(XLEN-10){in_word[31]}}, in_word[31:22]};
      case (in_word[7:4])
        4'b0100: tmode = M_RV;
        4'b0110: tmode = M_CX;
        4'b0101: tmode = M_NT;
        default: hit = 1'b0;
      endcase
    end
  end

  wire [XLEN-1:0] target = base_val + disp;
  wire take = in_valid && !redir_valid && !switch_fault;
  wire sw   = take && hit && (jcnt == 2'd0);
  wire mis  = (tmode == M_RV) ? target[0] : (target[1:0] != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode     <= M_RV;
      jcnt         <= 2'd0;
      redir_valid  <= 1'b0;
      switch_fault <= 1'b0;
      redir_mode   <= M_RV;
      redir_pc     <= '0;
    end else begin
      redir_valid  <= sw && !mis;
      switch_fault <= sw && mis;
      if (sw) begin
        redir_mode <= tmode;
        redir_pc   <= target;
      end
      if (sw && !mis) cur_mode <= tmode;
      if (take) begin
        if (!sw && iclass == C_JMB && jcnt != JMAX) jcnt <= jcnt + 2'd1;
        else jcnt <= 2'd0;
      end
    end
  end
endmodule

// File: rtl/isa_predecode_chk.sv
module isa_predecode_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     in_word,
  input logic [5:0]      base_idx,
  input logic [1:0]      cur_mode,
  input logic [1:0]      ilen_h,
  input logic [2:0]      iclass,
  input logic            illegal,
  input logic            jumbo_tail,
  input logic            redir_valid,
  input logic [1:0]      redir_mode,
  input logic [XLEN-1:0] redir_pc,
  input logic            switch_fault
);
  a_r1_reset_state: assert property (@(posedge clk) $rose(rst_n) |-> (cur_mode == 2'd0 && !redir_valid && !switch_fault));
  a_r2_rv_len: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'd0) |-> (ilen_h == ((in_word[1:0] == 2'b11) ? 2'd2 : 2'd1) && !illegal));
  a_r3_wide_len: assert property (@(posedge clk) disable iff (!rst_n) (cur_mode != 2'd0) |-> ilen_h == 2'd2);
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n) redir_valid |=> !redir_valid);
  a_r8_mode_follows: assert property (@(posedge clk) disable iff (!rst_n) redir_valid |-> cur_mode == redir_mode);
  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> ((redir_mode == 2'd0) ? !redir_pc[0] : (redir_pc[1:0] == 2'b00)));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(redir_valid && switch_fault));
  a_r9_fault_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n) switch_fault |-> $stable(cur_mode));
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n) (redir_valid || switch_fault) |=> (!redir_valid && !switch_fault));
  a_r11_tail_mode: assert property (@(posedge clk) disable iff (!rst_n) jumbo_tail |-> cur_mode != 2'd0);
endmodule

bind isa_predecode isa_predecode_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/isa_predecode_tb.sv
module isa_predecode_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = 32'h0;
  logic [63:0] base_val = 64'h0;
  logic [5:0]  base_idx;
  logic [1:0]  cur_mode, ilen_h, redir_mode;
  logic [2:0]  iclass;
  logic        illegal, jumbo_tail, redir_valid, switch_fault;
  logic [63:0] redir_pc;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  isa_predecode u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] f3(input logic [1:0] m);
    return (m == 2'd0) ? 3'b100 : (m == 2'd1) ? 3'b110 : 3'b101;
  endfunction
  function automatic logic [3:0] f4(input logic [1:0] m);
    return (m == 2'd0) ? 4'b0100 : (m == 2'd1) ? 4'b0110 : 4'b0101;
  endfunction
  function automatic logic [31:0] rv_sw(input logic [1:0] m, input logic [11:0] d, input logic [4:0] rs);
    return {d, rs, f3(m), 5'd0, 7'b0000011};
  endfunction
  function automatic logic [31:0] nat_sw(input logic [1:0] m, input logic [9:0] d, input logic [5:0] rs);
    return {d, rs, 2'b00, 6'd0, f4(m), 2'b11, 2'b00};
  endfunction

  task automatic send(input logic [31:0] w, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; base_val = b;
    #5;
  endtask
  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    #5;
  endtask
  task automatic setmode(input logic [1:0] m);
    send(rv_sw(m, 12'h000, 5'd1), 64'h1000);
    idle(); idle();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R1 mode", cur_mode, 0);
    check("R1 redir", redir_valid, 0);
    check("R1 fault", switch_fault, 0);

    for (int m = 0; m < 3; m++) begin
      setmode(m[1:0]);
      check("R8 setmode", cur_mode, m);
      for (int lo = 0; lo < 4; lo++)
        for (int blk = 0; blk < 4; blk++)
          for (int k = 0; k < 4; k++) begin
            logic [31:0] w;
            logic [2:0] ec; logic [1:0] el; logic ei; logic [5:0] eb;
            w = {k[15:0] * 16'h1357, 12'hF8F, blk[1:0], lo[1:0]};
            if (m == 0) begin
              ec = (lo == 3) ? 3'd1 : 3'd0; el = (lo == 3) ? 2'd2 : 2'd1; ei = 1'b0;
            end else begin
              el = 2'd2;
              ec = (lo == 0) ? 3'd2 : (lo == 1) ? 3'd3 : (lo == 2) ? 3'd4 : 3'd1;
              ei = (lo == 2) || (lo == 0 && blk == 1);
            end
            eb = (m != 0 && lo == 0) ? w[21:16] : {1'b0, w[19:15]};
            send(w, 64'h0);
            check(m == 0 ? "R2 class" : "R3 class", iclass, ec);
            check(m == 0 ? "R2 len" : "R3 len", ilen_h, el);
            check(blk == 1 ? "R4 illegal" : "R3 illegal", illegal, ei);
            check("R7 base_idx", base_idx, eb);
            send(32'h00000013, 64'h0);
          end
    end

    for (int s = 0; s < 3; s++)
      for (int t = 0; t < 3; t++) begin
        logic [63:0] b;
        b = 64'h8000_0000_0000_1000 + 64'(s * 256);
        setmode(s[1:0]);
        send(rv_sw(t[1:0], 12'hFF8, 5'd3), b);
        check("R7 rv idx", base_idx, 3);
        idle();
        check("R5 redir", redir_valid, 1);
        check("R8 redir_mode", redir_mode, t);
        check("R5 target", redir_pc, b - 64'd8);
        check("R8 cur_mode", cur_mode, t);
        idle();
        check("R8 one cycle", redir_valid, 0);
        if (s != 0) begin
          setmode(s[1:0]);
          send(nat_sw(t[1:0], 10'h3F0, 6'd37), b);
          check("R7 nat idx", base_idx, 37);
          idle();
          check("R6 redir", redir_valid, 1);
          check("R6 mode", cur_mode, t);
          check("R6 target", redir_pc, b - 64'd16);
          idle();
          check("R8 one cycle nat", redir_valid, 0);
        end
      end

    setmode(2'd0);
    send(nat_sw(2'd1, 10'h000, 6'd2), 64'h1000);
    check("R6 rvc class", iclass, 0);
    idle();
    check("R6 no switch in rv", redir_valid, 0);
    check("R6 mode kept", cur_mode, 0);
    send({12'h000, 5'd1, 3'b110, 5'd5, 7'b0000011}, 64'h1000);
    idle();
    check("R8 rd nonzero", redir_valid, 0);
    send({12'h000, 5'd1, 3'b011, 5'd0, 7'b0000011}, 64'h1000);
    idle();
    check("R8 other funct3", redir_valid, 0);

    send(rv_sw(2'd1, 12'h002, 5'd1), 64'h1000);
    idle();
    check("R9 fault cx", switch_fault, 1);
    check("R9 no redir", redir_valid, 0);
    check("R9 mode kept", cur_mode, 0);
    idle();
    check("R9 fault pulse", switch_fault, 0);
    send(rv_sw(2'd0, 12'h001, 5'd1), 64'h1000);
    idle();
    check("R9 fault odd rv", switch_fault, 1);
    idle();
    send(rv_sw(2'd0, 12'h002, 5'd1), 64'h1000);
    idle();
    check("R9 rv half ok", redir_valid, 1);
    check("R9 rv half pc", redir_pc, 64'h1002);
    idle();
    setmode(2'd2);
    send(nat_sw(2'd2, 10'h001, 6'd4), 64'h2000);
    idle();
    check("R9 nat fault", switch_fault, 1);
    check("R9 nat mode kept", cur_mode, 2);
    idle();

    setmode(2'd0);
    send(rv_sw(2'd1, 12'h000, 5'd1), 64'h1000);
    send(rv_sw(2'd2, 12'h000, 5'd1), 64'h2000);
    check("R10 redir during drop", redir_valid, 1);
    idle();
    check("R10 dropped", redir_valid, 0);
    check("R10 mode", cur_mode, 1);
    idle();

    setmode(2'd1);
    send(32'h0000_0001, 64'h0);
    check("R11 first prefix tail", jumbo_tail, 0);
    send(32'h0000_0001, 64'h0);
    check("R11 second prefix tail", jumbo_tail, 1);
    check("R11 second legal", illegal, 0);
    send(32'h0000_0001, 64'h0);
    check("R11 third tail", jumbo_tail, 1);
    check("R11 third illegal", illegal, 1);
    send(32'h00000013, 64'h0);
    check("R11 chain ended", jumbo_tail, 0);
    send(32'h0000_0001, 64'h0);
    send(rv_sw(2'd2, 12'h000, 5'd1), 64'h1000);
    check("R11 switch as tail", jumbo_tail, 1);
    idle();
    check("R11 no switch", redir_valid, 0);
    check("R11 mode kept", cur_mode, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule